// File: doc/BRIEF.md
# Scan State Justify/Observe Translator

This unit sits on the tester side of a three-stage scan register whose bits can be disguised by XOR terms inside the chain. It performs two operations. A justify operation takes a wanted final register state and emits, one bit per clock, the serial input sequence that leaves the register holding that state after three shifts, whatever it held before. An observe operation takes in three bits that are shifted out of the register and rebuilds the state the register held before the shift began.

A mode input picks the equations. Plain mode treats the chain as an ordinary shift register. Disguised mode applies the XOR corrections of a chain whose third stage loads the XOR of the first two stages and whose output is the XOR of the last two stages. With one mode input the same unit can drive and read both kinds of register.

The controller is a four-state machine. IDLE moves to EMIT on an accepted justify start, or to SAMPLE on an accepted observe start. EMIT and SAMPLE each stay for three cycles and then move to FINISH. FINISH always returns to IDLE after one cycle. The start input is acted on only in IDLE. The target, the operation and the mode are captured on that same edge.

Top module: `scan_xlate`

## Requirements
- R1: While reset is held low and on release of reset, `busy`, `done` and `scan_out_vld` are 0 and `state_out` is 000.
- R2: A justify start (`op`=0) with `mode`=0 makes `scan_out` carry y3, y2, y1 on the three cycles after the start edge, with `scan_out_vld` high on exactly those cycles. Here `target[0]`=y1, `target[1]`=y2 and `target[2]`=y3.
- R3: A justify start with `mode`=1 emits y3^y2, y2, y1 in the same three cycles. Shifting this sequence into a disguised chain leaves it in the target state, from any starting state.
- R4: An observe start (`op`=1) with `mode`=0 samples `scan_in` on the three edges after the start edge, as z0, z1, z2. It then sets `state_out` to y1=z2, y2=z1, y3=z0.
- R5: An observe with `mode`=1 sets `state_out` to y1=z2, y2=z1, y3=z0^z1.
- R6: `done` is a single-cycle pulse in the cycle after the third serial cycle. `busy` is high from the cycle after an accepted start through the `done` cycle, and falls only after `done`.
- R7: A start raised while `busy` is high, including in the `done` cycle, is ignored. The running operation keeps its captured target, operation and mode, and no new operation begins.
- R8: `state_out` changes only in the cycle where `done` is high. A justify operation leaves it unchanged.
- R9: For every target and either chain type, a justify followed by an observe in the matching mode returns the requested state on `state_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation, sampled in IDLE only |
| op | input | 1 | 0 = justify, 1 = observe |
| mode | input | 1 | 0 = plain equations, 1 = disguised equations |
| target | input | 3 | Wanted final state, bit0 = y1, bit2 = y3 |
| scan_in | input | 1 | Serial bit from the scan register output |
| scan_out | output | 1 | Serial bit to drive into the scan register |
| scan_out_vld | output | 1 | High while `scan_out` carries a justify bit |
| state_out | output | 3 | Recovered state, bit0 = y1, bit2 = y3 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives a behavioural model of both chain types from the unit's own serial output and feeds the model's output back to `scan_in`. It runs every target through justify and then observe. A unit that simply reversed the bits in disguised mode would leave y3 wrong whenever y2 is 1. A unit that applied the correction to the wrong observed bit would fail the same round trips. Starts are raised one cycle into an operation and again in the `done` cycle; a unit that restarted would put extra serial bits on the wire or corrupt the final state. A justify run in plain mode into a disguised chain must leave y3^y2 in the third stage. A justify between two observes must not disturb `state_out`.

// File: rtl/scan_xlate_pkg.sv
package scan_xlate_pkg;
    localparam int unsigned XL_STAGES = 3;
    localparam int unsigned XL_CNT_W  = $clog2(XL_STAGES);

    typedef enum logic [1:0] {
        XL_IDLE   = 2'd0,
        XL_EMIT   = 2'd1,
        XL_SAMPLE = 2'd2,
        XL_FINISH = 2'd3
    } xl_state_e;

    typedef enum logic {
        OP_JUSTIFY = 1'b0,
        OP_OBSERVE = 1'b1
    } xl_op_e;

    typedef enum logic {
        EQ_PLAIN     = 1'b0,
        EQ_DISGUISED = 1'b1
    } xl_eq_e;
endpackage

// File: rtl/xlate_eqn.sv
// Fixed linear equations for the three-stage chain.
// Bit i of a state vector is stage y(i+1); bit i of a sequence is x(i) or z(i).
module xlate_eqn
    import scan_xlate_pkg::*;
(
    input  xl_eq_e                 jmode,
    input  logic [XL_STAGES-1:0]   want,
    output logic [XL_STAGES-1:0]   seq,
    input  xl_eq_e                 omode,
    input  logic [XL_STAGES-1:0]   zvec,
    output logic [XL_STAGES-1:0]   recov
);
    // Justify: first bit lands in the last stage, last bit in the first stage.
    always_comb begin
        seq[0] = want[2];
        seq[1] = want[1];
        seq[2] = want[0];
        if (jmode == EQ_DISGUISED) begin
            seq[0] = want[2] ^ want[1];
        end
    end

    // Observe: first bit out came from the last stage.
    always_comb begin
        recov[0] = zvec[2];
        recov[1] = zvec[1];
        recov[2] = zvec[0];
        if (omode == EQ_DISGUISED) begin
            recov[2] = zvec[0] ^ zvec[1];
        end
    end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
    import scan_xlate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  xl_op_e op,
    output logic   accept,
    output logic   emit,
    output logic   sample,
    output logic   last,
    output logic   busy,
    output logic   done
);
    xl_state_e             state_q;
    xl_state_e             state_d;
    logic [XL_CNT_W-1:0]   cnt_q;
    logic                  run;

    localparam logic [XL_CNT_W-1:0] CNT_LAST = XL_CNT_W'(XL_STAGES - 1);

    assign run  = (state_q == XL_EMIT) || (state_q == XL_SAMPLE);
    assign last = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XL_IDLE: begin
                if (start) begin
                    state_d = (op == OP_OBSERVE) ? XL_SAMPLE : XL_EMIT;
                end
            end
            XL_EMIT: begin
                if (last) state_d = XL_FINISH;
            end
            XL_SAMPLE: begin
                if (last) state_d = XL_FINISH;
            end
            XL_FINISH: begin
                state_d = XL_IDLE;
            end
            default: state_d = XL_IDLE;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        emit   = 1'b0;
        sample = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state_q)
            XL_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            XL_EMIT:   emit   = 1'b1;
            XL_SAMPLE: sample = 1'b1;
            XL_FINISH: done   = 1'b1;
            default:   busy   = 1'b0;
        endcase
    end
endmodule

// File: rtl/xlate_serial.sv
// Parallel-load serialiser for justify, shift-in collector for observe.
module xlate_serial
    import scan_xlate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [XL_STAGES-1:0]  load_val,
    input  logic                  emit,
    output logic                  ser_bit,
    input  logic                  sample,
    input  logic                  ser_in,
    output logic [XL_STAGES-1:0]  znext
);
    logic [XL_STAGES-1:0] out_q;
    logic [XL_STAGES-1:0] in_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (load) begin
            out_q <= load_val;
        end else if (emit) begin
            out_q <= {1'b0, out_q[XL_STAGES-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0;
        end else if (sample) begin
            in_q <= znext;
        end
    end

    assign ser_bit = out_q[0];
    // After the last sample, bit 0 holds the first bit taken in.
    assign znext   = {ser_in, in_q[XL_STAGES-1:1]};
endmodule

// File: rtl/scan_xlate.sv
module scan_xlate
    import scan_xlate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  op,
    input  logic                  mode,
    input  logic [XL_STAGES-1:0]  target,
    input  logic                  scan_in,
    output logic                  scan_out,
    output logic                  scan_out_vld,
    output logic [XL_STAGES-1:0]  state_out,
    output logic                  busy,
    output logic                  done
);
    logic                  accept;
    logic                  emit;
    logic                  sample;
    logic                  last;
    logic                  load;
    xl_eq_e                mode_q;
    logic [XL_STAGES-1:0]  seq;
    logic [XL_STAGES-1:0]  znext;
    logic [XL_STAGES-1:0]  recov;
    logic [XL_STAGES-1:0]  state_q;

    xlate_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op     (xl_op_e'(op)),
        .accept (accept),
        .emit   (emit),
        .sample (sample),
        .last   (last),
        .busy   (busy),
        .done   (done)
    );

    assign load = accept && (xl_op_e'(op) == OP_JUSTIFY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= EQ_PLAIN;
        end else if (accept) begin
            mode_q <= xl_eq_e'(mode);
        end
    end

    xlate_eqn u_eqn (
        .jmode (xl_eq_e'(mode)),
        .want  (target),
        .seq   (seq),
        .omode (mode_q),
        .zvec  (znext),
        .recov (recov)
    );

    xlate_serial u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (seq),
        .emit     (emit),
        .ser_bit  (scan_out),
        .sample   (sample),
        .ser_in   (scan_in),
        .znext    (znext)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (sample && last) begin
            state_q <= recov;
        end
    end

    assign state_out    = state_q;
    assign scan_out_vld = emit;
endmodule

// File: rtl/scan_xlate_chk.sv
module scan_xlate_chk
    import scan_xlate_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  scan_out_vld,
    input logic [XL_STAGES-1:0]  state_out,
    input logic                  busy,
    input logic                  done
);
    AST_VLD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out_vld |-> busy) else $error("vld outside busy");                  // R2
    AST_VLD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_out_vld) |=> scan_out_vld) else $error("vld run too short");   // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle");               // R6
    AST_DONE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !scan_out_vld)) else $error("done overlaps serial");   // R6
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done)) else $error("busy fell without done");      // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy) else $error("start disturbed run");   // R7
    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(state_out)) else $error("state_out moved");            // R8
endmodule

bind scan_xlate scan_xlate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .scan_out_vld (scan_out_vld),
    .state_out    (state_out),
    .busy         (busy),
    .done         (done)
);

// File: tb/sim_scan_xlate.sv
module sim_scan_xlate;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       op = 1'b0;
    logic       mode = 1'b0;
    logic [2:0] target = 3'b000;
    logic       scan_in;
    logic       scan_out;
    logic       scan_out_vld;
    logic [2:0] state_out;
    logic       busy;
    logic       done;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_xlate u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode),
        .target(target), .scan_in(scan_in), .scan_out(scan_out),
        .scan_out_vld(scan_out_vld), .state_out(state_out),
        .busy(busy), .done(done)
    );

    // Behavioural chain: bit0 = y1, bit2 = y3.
    logic [2:0] mdl_y = 3'b000;
    logic       mdl_disg = 1'b0;
    logic       pre_en = 1'b0;
    logic [2:0] pre_val = 3'b000;
    logic       fill_bit = 1'b0;

    assign scan_in = mdl_disg ? (mdl_y[2] ^ mdl_y[1]) : mdl_y[2];

    always @(posedge clk) begin
        logic x;
        if (pre_en) begin
            mdl_y <= pre_val;
        end else if (busy && !done) begin
            x = scan_out_vld ? scan_out : fill_bit;
            mdl_y <= {(mdl_disg ? (mdl_y[1] ^ mdl_y[0]) : mdl_y[1]), mdl_y[0], x};
        end
    end

    always @(negedge clk) fill_bit <= 1'($urandom);

    // Expected per-cycle outputs: bit0 vld, bit1 data, bit2 done, bit3 busy.
    int    exp_q[$];
    string req_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int    e;
        string r;
        #(CLK_PERIOD/4);
        if (rst_n) begin
            e = 0;
            r = "R6";
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                r = req_q.pop_front();
            end
            check({busy, done, scan_out_vld} == {e[3], e[2], e[0]}, r,
                  {busy, done, scan_out_vld}, {e[3], e[2], e[0]});
            if (e[0]) check(scan_out == e[1], r, scan_out, e[1]);
        end
    end

    function automatic logic [2:0] jseq(input logic [2:0] t, input logic m);
        // returns {x2, x1, x0}
        return {t[0], t[1], (m ? (t[2] ^ t[1]) : t[2])};
    endfunction

    task automatic preload(input logic [2:0] v, input logic disg);
        @(negedge clk);
        mdl_disg = disg;
        pre_val  = v;
        pre_en   = 1'b1;
        @(negedge clk);
        pre_en   = 1'b0;
    endtask

    // poke: raise a conflicting start one cycle in and again in the done cycle.
    task automatic justify(input logic [2:0] t, input logic m, input bit poke,
                           input string req);
        logic [2:0] s;
        s = jseq(t, m);
        @(negedge clk);
        start = 1'b1; op = 1'b0; mode = m; target = t;
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(8 | (int'(s[i]) << 1) | 1);
            req_q.push_back(req);
        end
        exp_q.push_back(8 | 4);
        req_q.push_back("R6");
        @(negedge clk);
        if (poke) begin
            op = 1'b1; mode = ~m; target = ~t;
            @(negedge clk);
            start = 1'b0;
            repeat (2) @(posedge clk);
        end else begin
            start = 1'b0;
            repeat (3) @(posedge clk);
        end
        #(CLK_PERIOD/4);
        if (poke) begin
            @(negedge clk);
            start = 1'b1; op = 1'b1;   // lands on the done cycle edge
            @(negedge clk);
            start = 1'b0;
            #(CLK_PERIOD/4);
            check(busy == 1'b0, "R7 done-cycle start", busy, 0);
            @(posedge clk);
        end else begin
            @(posedge clk);
        end
    endtask

    task automatic observe(input logic m, input logic [2:0] want, input string req);
        @(negedge clk);
        start = 1'b1; op = 1'b1; mode = m;
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(8);
            req_q.push_back(req);
        end
        exp_q.push_back(8 | 4);
        req_q.push_back("R6");
        @(negedge clk);
        start = 1'b0; mode = ~m;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check(state_out == want, req, state_out, want);
        @(posedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] got;
        repeat (3) @(negedge clk);
        check({busy, done, scan_out_vld, state_out} == 6'd0, "R1 in reset",
              {busy, done, scan_out_vld, state_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, scan_out_vld, state_out} == 6'd0, "R1 after reset",
              {busy, done, scan_out_vld, state_out}, 0);

        // Plain chain: R2 emission, R4 recovery, R9 round trip.
        for (int t = 0; t < 8; t++) begin
            preload(3'(t * 5 + 3), 1'b0);
            justify(3'(t), 1'b0, 1'b0, "R2");
            check(mdl_y == 3'(t), "R2 plain chain state", mdl_y, t);
            observe(1'b0, 3'(t), "R4 R9");
        end

        // Disguised chain: R3 emission, R5 recovery, R9 round trip.
        for (int t = 0; t < 8; t++) begin
            preload(3'(t * 3 + 1), 1'b1);
            justify(3'(t), 1'b1, 1'b0, "R3");
            check(mdl_y == 3'(t), "R3 disguised chain state", mdl_y, t);
            observe(1'b1, 3'(t), "R5 R9");
        end

        // R5: observe disguised from arbitrary preloaded states.
        preload(3'b101, 1'b1);
        observe(1'b1, 3'b101, "R5 direct");
        preload(3'b110, 1'b1);
        observe(1'b1, 3'b110, "R5 direct");

        // R8: justify leaves state_out untouched.
        got = state_out;
        preload(3'b000, 1'b1);
        justify(3'b011, 1'b1, 1'b0, "R3");
        check(state_out == got, "R8 hold across justify", state_out, got);

        // Plain equations into disguised chain: y3 ends as y3^y2.
        preload(3'b000, 1'b1);
        justify(3'b010, 1'b0, 1'b0, "R2");
        check(mdl_y == 3'b110, "R3 mode mismatch", mdl_y, 3'b110);

        // R7: conflicting starts while busy change nothing.
        preload(3'b111, 1'b1);
        got = state_out;
        justify(3'b100, 1'b1, 1'b1, "R7");
        check(mdl_y == 3'b100, "R7 target kept", mdl_y, 3'b100);
        check(state_out == got, "R7 no observe started", state_out, got);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule